// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a small set of hardware semaphore flags that two independent agents, a left side and a right side, use to decide which of them may touch a shared resource. Each side has its own simple register-style access port. A side claims a semaphore by writing a request to it, and later reads the semaphore back to see whether it now owns it. A side gives up a semaphore by writing a release to it.

Each semaphore keeps a request latch for each side, so a request that arrives while the other side owns the flag is not lost. That request stays pending, and the flag passes to the waiting side on the cycle the owner releases it. The waiting side does not need to write again. The semaphores are independent of one another. Each is a five-state machine:

- `SEM_FREE`: no owner.
- `SEM_LEFT`: left owns, nothing pending.
- `SEM_RIGHT`: right owns, nothing pending.
- `SEM_LEFT_RQ`: left owns, right pending.
- `SEM_RIGHT_LQ`: right owns, left pending.

The transitions are:

- **claim**: `SEM_FREE` to `SEM_LEFT` or `SEM_RIGHT`.
- **dual claim**: `SEM_FREE` to `SEM_LEFT_RQ`.
- **queue**: `SEM_LEFT` to `SEM_LEFT_RQ`, or `SEM_RIGHT` to `SEM_RIGHT_LQ`.
- **drop**: owner release, `SEM_LEFT` or `SEM_RIGHT` to `SEM_FREE`.
- **hand-over**: owner release with the other side pending, `SEM_LEFT_RQ` to `SEM_RIGHT`, or `SEM_RIGHT_LQ` to `SEM_LEFT`.
- **withdraw**: a pending side releases, `SEM_LEFT_RQ` to `SEM_LEFT`, or `SEM_RIGHT_LQ` to `SEM_RIGHT`.
- **double drop**: both sides release together while one is pending, `SEM_LEFT_RQ` or `SEM_RIGHT_LQ` to `SEM_FREE`.

Top module: `twoport_sem_bank`

## Requirements
- R1: The bank has 8 independent semaphores selected by a 3-bit index; an operation on one index never changes another.
- R2: After reset every semaphore is free with nothing pending, and both readback outputs are 1.
- R3: A write with data bit 0 is a request; a request to a free semaphore makes the writer its owner at the clock edge of the write.
- R4: A read strobe at a clock edge loads the readback output with 0 if that side owns the indexed semaphore just before that edge, else 1; it is valid from that edge on.
- R5: A request to a semaphore owned by the other side leaves the owner unchanged, reads 1 (denied) and latches a pending request.
- R6: If both sides request the same free semaphore at the same edge, the left side becomes owner and the right side's request is pending.
- R7: A write with data bit 1 is a release; when the owner releases and the other side has a request pending or requests at that same edge, the other side becomes owner without writing again.
- R8: When the owner releases with no request from the other side, the semaphore becomes free.
- R9: A release from a side that neither owns nor has requested the semaphore has no effect.
- R10: A release from a side whose request is pending withdraws that request; a later owner release then leaves the semaphore free.
- R11: A request from the side that already owns the semaphore has no effect.
- R12: The two sides are never both owner of one semaphore; reading the same index together never returns 0 on both sides.
- R13: The readback output holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_idx | input | 3 | Left side semaphore index |
| l_wr | input | 1 | Left side write strobe |
| l_wdata | input | 1 | Left side write bit: 0 request, 1 release |
| l_rd | input | 1 | Left side read strobe |
| l_rdata | output | 1 | Left side readback: 0 granted, 1 denied |
| r_idx | input | 3 | Right side semaphore index |
| r_wr | input | 1 | Right side write strobe |
| r_wdata | input | 1 | Right side write bit: 0 request, 1 release |
| r_rd | input | 1 | Right side read strobe |
| r_rdata | output | 1 | Right side readback: 0 granted, 1 denied |

## Verification
A cell in the wrong state shows at the ports on the first read after the faulty edge. Examples are a lost pending latch or an owner taken over with no release. Such a read returns a grant to the wrong side, or a denial to the rightful owner. A pending latch that is lost or invented cannot be seen from any read while the owner holds the flag. It shows only after the owner's release, which is one write cycle plus one read cycle later. The bench therefore follows every case with an owner release and a second read. It sweeps every index, every reachable state and every pair of left and right operations.

// File: rtl/twoport_sem_pkg.sv
package twoport_sem_pkg;

    typedef enum logic [2:0] {
        SEM_FREE     = 3'd0,
        SEM_LEFT     = 3'd1,
        SEM_RIGHT    = 3'd2,
        SEM_LEFT_RQ  = 3'd3,
        SEM_RIGHT_LQ = 3'd4
    } sem_state_t;

    typedef struct packed {
        logic req;
        logic rel;
    } sem_op_t;

    localparam logic WBIT_REQUEST = 1'b0;
    localparam logic WBIT_RELEASE = 1'b1;

endpackage

// File: rtl/twoport_sem_decode.sv
module twoport_sem_decode
    import twoport_sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    input  logic             wdata,
    output sem_op_t          ops [NUM_SEM]
);

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_op
        logic hit;
        always_comb begin
            hit        = wr && (idx == IDX_W'(g));
            ops[g].req = hit && (wdata == WBIT_REQUEST);
            ops[g].rel = hit && (wdata == WBIT_RELEASE);
        end
    end

endmodule

// File: rtl/twoport_sem_cell.sv
module twoport_sem_cell
    import twoport_sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sem_op_t l_op,
    input  sem_op_t r_op,
    output logic    own_l,
    output logic    own_r,
    output logic    wait_l,
    output logic    wait_r
);

    sem_state_t state_q;
    sem_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (l_op.req && r_op.req) begin
                    state_d = SEM_LEFT_RQ;
                end else if (l_op.req) begin
                    state_d = SEM_LEFT;
                end else if (r_op.req) begin
                    state_d = SEM_RIGHT;
                end
            end
            SEM_LEFT: begin
                if (l_op.rel) begin
                    state_d = r_op.req ? SEM_RIGHT : SEM_FREE;
                end else if (r_op.req) begin
                    state_d = SEM_LEFT_RQ;
                end
            end
            SEM_RIGHT: begin
                if (r_op.rel) begin
                    state_d = l_op.req ? SEM_LEFT : SEM_FREE;
                end else if (l_op.req) begin
                    state_d = SEM_RIGHT_LQ;
                end
            end
            SEM_LEFT_RQ: begin
                if (l_op.rel) begin
                    state_d = r_op.rel ? SEM_FREE : SEM_RIGHT;
                end else if (r_op.rel) begin
                    state_d = SEM_LEFT;
                end
            end
            SEM_RIGHT_LQ: begin
                if (r_op.rel) begin
                    state_d = l_op.rel ? SEM_FREE : SEM_LEFT;
                end else if (l_op.rel) begin
                    state_d = SEM_RIGHT;
                end
            end
            default: state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        own_l  = 1'b0;
        own_r  = 1'b0;
        wait_l = 1'b0;
        wait_r = 1'b0;
        unique case (state_q)
            SEM_FREE:     ;
            SEM_LEFT:     own_l = 1'b1;
            SEM_RIGHT:    own_r = 1'b1;
            SEM_LEFT_RQ: begin
                own_l  = 1'b1;
                wait_r = 1'b1;
            end
            SEM_RIGHT_LQ: begin
                own_r  = 1'b1;
                wait_l = 1'b1;
            end
            default:      ;
        endcase
    end

endmodule

// File: rtl/twoport_sem_readback.sv
module twoport_sem_readback #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] own,
    output logic               rdata
);

    logic denied;

    always_comb begin
        denied = 1'b1;
        for (int k = 0; k < NUM_SEM; k++) begin
            if (idx == IDX_W'(k)) begin
                denied = ~own[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= 1'b1;
        end else if (rd) begin
            rdata <= denied;
        end
    end

endmodule

// File: rtl/twoport_sem_bank.sv
module twoport_sem_bank
    import twoport_sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wr,
    input  logic             l_wdata,
    input  logic             l_rd,
    output logic             l_rdata,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wr,
    input  logic             r_wdata,
    input  logic             r_rd,
    output logic             r_rdata
);

    sem_op_t            l_ops [NUM_SEM];
    sem_op_t            r_ops [NUM_SEM];
    logic [NUM_SEM-1:0] own_l_vec;
    logic [NUM_SEM-1:0] own_r_vec;
    logic [NUM_SEM-1:0] wait_l_vec;
    logic [NUM_SEM-1:0] wait_r_vec;

    twoport_sem_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) l_dec_i (
        .idx   (l_idx),
        .wr    (l_wr),
        .wdata (l_wdata),
        .ops   (l_ops)
    );

    twoport_sem_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) r_dec_i (
        .idx   (r_idx),
        .wr    (r_wr),
        .wdata (r_wdata),
        .ops   (r_ops)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        twoport_sem_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_op   (l_ops[g]),
            .r_op   (r_ops[g]),
            .own_l  (own_l_vec[g]),
            .own_r  (own_r_vec[g]),
            .wait_l (wait_l_vec[g]),
            .wait_r (wait_r_vec[g])
        );
    end

    twoport_sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) l_rb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (l_rd),
        .idx   (l_idx),
        .own   (own_l_vec),
        .rdata (l_rdata)
    );

    twoport_sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) r_rb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (r_rd),
        .idx   (r_idx),
        .own   (own_r_vec),
        .rdata (r_rdata)
    );

endmodule

// File: rtl/twoport_sem_bank_chk.sv
module twoport_sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IDX_W-1:0]   l_idx,
    input logic               l_wr,
    input logic               l_wdata,
    input logic               l_rd,
    input logic               l_rdata,
    input logic [IDX_W-1:0]   r_idx,
    input logic               r_wr,
    input logic               r_wdata,
    input logic               r_rd,
    input logic               r_rdata,
    input logic [NUM_SEM-1:0] own_l_vec,
    input logic [NUM_SEM-1:0] own_r_vec,
    input logic [NUM_SEM-1:0] wait_l_vec,
    input logic [NUM_SEM-1:0] wait_r_vec
);

    // R12
    both_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && r_rd && (l_idx == r_idx)) |=> !(!l_rdata && !r_rdata));

    // R13
    l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata));

    // R13
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata));

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
        logic l_rel_here;
        logic r_rel_here;
        logic l_req_here;
        logic r_req_here;
        assign l_rel_here = l_wr && l_wdata && (l_idx == IDX_W'(g));
        assign r_rel_here = r_wr && r_wdata && (r_idx == IDX_W'(g));
        assign l_req_here = l_wr && !l_wdata && (l_idx == IDX_W'(g));
        assign r_req_here = r_wr && !r_wdata && (r_idx == IDX_W'(g));

        // R9
        l_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && !l_rel_here) |=> own_l_vec[g]);

        // R9
        r_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r_vec[g] && !r_rel_here) |=> own_r_vec[g]);

        // R6
        left_wins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (l_req_here && !own_l_vec[g] && !own_r_vec[g]) |=> own_l_vec[g]);

        // R3
        right_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_req_here && !l_req_here && !own_l_vec[g] && !own_r_vec[g]) |=> own_r_vec[g]);

        // R7
        handover_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && wait_r_vec[g] && l_rel_here && !r_rel_here) |=> own_r_vec[g]);

        // R7
        handover_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r_vec[g] && wait_l_vec[g] && r_rel_here && !l_rel_here) |=> own_l_vec[g]);

        // R8
        drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && !wait_r_vec[g] && l_rel_here && !r_req_here) |=> !own_l_vec[g] && !own_r_vec[g]);
    end

endmodule

bind twoport_sem_bank twoport_sem_bank_chk #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .l_idx      (l_idx),
    .l_wr       (l_wr),
    .l_wdata    (l_wdata),
    .l_rd       (l_rd),
    .l_rdata    (l_rdata),
    .r_idx      (r_idx),
    .r_wr       (r_wr),
    .r_wdata    (r_wdata),
    .r_rd       (r_rd),
    .r_rdata    (r_rdata),
    .own_l_vec  (own_l_vec),
    .own_r_vec  (own_r_vec),
    .wait_l_vec (wait_l_vec),
    .wait_r_vec (wait_r_vec)
);

// File: tb/twoport_sem_bank_tb_top.sv
module twoport_sem_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSEM       = 8;
    localparam int OP_NONE    = 0;
    localparam int OP_REQ     = 1;
    localparam int OP_REL     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] l_idx = '0;
    logic       l_wr = 1'b0;
    logic       l_wdata = 1'b0;
    logic       l_rd = 1'b0;
    logic       l_rdata;
    logic [2:0] r_idx = '0;
    logic       r_wr = 1'b0;
    logic       r_wdata = 1'b0;
    logic       r_rd = 1'b0;
    logic       r_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model: owner 0 none, 1 left, 2 right
    int m_own [NSEM];
    bit m_pl  [NSEM];
    bit m_pr  [NSEM];

    always #(CLK_PERIOD/2) clk = ~clk;

    twoport_sem_bank dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_idx   (l_idx),
        .l_wr    (l_wr),
        .l_wdata (l_wdata),
        .l_rd    (l_rd),
        .l_rdata (l_rdata),
        .r_idx   (r_idx),
        .r_wr    (r_wr),
        .r_wdata (r_wdata),
        .r_rd    (r_rd),
        .r_rdata (r_rdata)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int k = 0; k < NSEM; k++) begin
            m_own[k] = 0;
            m_pl[k]  = 1'b0;
            m_pr[k]  = 1'b0;
        end
    endtask

    task automatic m_apply(input int lop, input int li, input int rop, input int ri);
        if (lop == OP_REQ) begin
            if (m_own[li] == 0) m_own[li] = 1;
            else if (m_own[li] == 2) m_pl[li] = 1'b1;
        end
        if (rop == OP_REQ) begin
            if (m_own[ri] == 0) m_own[ri] = 2;
            else if (m_own[ri] == 1) m_pr[ri] = 1'b1;
        end
        if (lop == OP_REL) begin
            if (m_own[li] == 1) begin
                m_own[li] = m_pr[li] ? 2 : 0;
                m_pr[li]  = 1'b0;
            end else begin
                m_pl[li] = 1'b0;
            end
        end
        if (rop == OP_REL) begin
            if (m_own[ri] == 2) begin
                m_own[ri] = m_pl[ri] ? 1 : 0;
                m_pl[ri]  = 1'b0;
            end else begin
                m_pr[ri] = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    // one write cycle on both sides, model updated alongside
    task automatic cyc(input int lop, input int li, input int rop, input int ri);
        @(negedge clk);
        l_idx   = 3'(li);
        l_wr    = (lop != OP_NONE);
        l_wdata = (lop == OP_REL);
        r_idx   = 3'(ri);
        r_wr    = (rop != OP_NONE);
        r_wdata = (rop == OP_REL);
        @(posedge clk);
        #1;
        l_wr = 1'b0;
        r_wr = 1'b0;
        m_apply(lop, li, rop, ri);
    endtask

    // read both sides; values sampled at the following negedge
    task automatic rd_both(input int li, input int ri);
        @(negedge clk);
        l_idx = 3'(li);
        r_idx = 3'(ri);
        l_rd  = 1'b1;
        r_rd  = 1'b1;
        @(posedge clk);
        #1;
        l_rd = 1'b0;
        r_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_model(input string tag, input int i);
        rd_both(i, i);
        check(tag, l_rdata, (m_own[i] == 1) ? 1'b0 : 1'b1);
        check(tag, r_rdata, (m_own[i] == 2) ? 1'b0 : 1'b1);
        check({tag, " R12"}, (!l_rdata && !r_rdata), 1'b0);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: reset state
        check("R2 l_rdata after reset", l_rdata, 1'b1);
        check("R2 r_rdata after reset", r_rdata, 1'b1);
        for (int i = 0; i < NSEM; i++) begin
            rd_both(i, i);
            check("R2 left free", l_rdata, 1'b1);
            check("R2 right free", r_rdata, 1'b1);
        end

        // R1, R3, R4: independent indices
        cyc(OP_REQ, 2, OP_REQ, 5);
        rd_both(2, 5);
        check("R3 left claim idx2", l_rdata, 1'b0);
        check("R1 right claim idx5", r_rdata, 1'b0);
        rd_both(5, 2);
        check("R1 left reads idx5", l_rdata, 1'b1);
        check("R4 right reads idx2", r_rdata, 1'b1);

        // R13: hold without read, even after ownership changes
        rd_both(2, 2);
        cyc(OP_REL, 2, OP_NONE, 0);
        @(negedge clk);
        check("R13 left hold", l_rdata, 1'b0);
        check("R13 right hold", r_rdata, 1'b1);
        rd_both(2, 2);
        check("R8 free after drop", l_rdata, 1'b1);

        // R5, R7: pending then hand-over
        do_reset();
        cyc(OP_REQ, 6, OP_NONE, 0);
        cyc(OP_NONE, 0, OP_REQ, 6);
        chk_model("R5 denied while left owns", 6);
        check("R5 right denied", r_rdata, 1'b1);
        cyc(OP_REL, 6, OP_NONE, 0);
        rd_both(6, 6);
        check("R7 right granted after release", r_rdata, 1'b0);

        // R6: simultaneous request
        do_reset();
        cyc(OP_REQ, 1, OP_REQ, 1);
        rd_both(1, 1);
        check("R6 left wins", l_rdata, 1'b0);
        check("R6 right denied", r_rdata, 1'b1);

        // R9: stray release
        do_reset();
        cyc(OP_REQ, 3, OP_NONE, 0);
        cyc(OP_NONE, 0, OP_REL, 3);
        rd_both(3, 3);
        check("R9 owner kept", l_rdata, 1'b0);
        cyc(OP_REL, 3, OP_NONE, 0);
        rd_both(3, 3);
        check("R9 no pending created", r_rdata, 1'b1);

        // R10: withdraw pending
        do_reset();
        cyc(OP_NONE, 0, OP_REQ, 4);
        cyc(OP_REQ, 4, OP_NONE, 0);
        cyc(OP_REL, 4, OP_NONE, 0);
        cyc(OP_NONE, 0, OP_REL, 4);
        rd_both(4, 4);
        check("R10 left not granted", l_rdata, 1'b1);
        check("R10 right released", r_rdata, 1'b1);

        // R11: owner repeat request
        do_reset();
        cyc(OP_REQ, 7, OP_NONE, 0);
        cyc(OP_REQ, 7, OP_NONE, 0);
        cyc(OP_REL, 7, OP_NONE, 0);
        rd_both(7, 7);
        check("R11 single release frees", l_rdata, 1'b1);

        // sweep: every index, start state, op pair; then owner release
        for (int i = 0; i < NSEM; i++) begin
            for (int st = 0; st < 5; st++) begin
                for (int c = 0; c < 9; c++) begin
                    do_reset();
                    case (st)
                        1: cyc(OP_REQ, i, OP_NONE, 0);
                        2: cyc(OP_NONE, 0, OP_REQ, i);
                        3: begin cyc(OP_REQ, i, OP_NONE, 0); cyc(OP_NONE, 0, OP_REQ, i); end
                        4: begin cyc(OP_NONE, 0, OP_REQ, i); cyc(OP_REQ, i, OP_NONE, 0); end
                        default: ;
                    endcase
                    cyc(c % 3, i, c / 3, i);
                    chk_model("sweep after ops", i);
                    if (m_own[i] == 1) cyc(OP_REL, i, OP_NONE, 0);
                    else if (m_own[i] == 2) cyc(OP_NONE, 0, OP_REL, i);
                    chk_model("sweep after owner release", i);
                    rd_both((i + 1) % NSEM, (i + 1) % NSEM);
                    check("R1 neighbour untouched", l_rdata & r_rdata, 1'b1);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule